// File: doc/BRIEF.md
# Interrupt and Break Entry Sequencer

This block runs the stack traffic that surrounds control transfers on an 8-bit processor whose stack sits in page one. When a hardware interrupt is taken, or when the core signals a software break, it saves the return address and the status byte on the stack and fetches a new program counter from a 16-bit little-endian vector. When the core signals a return from interrupt or a return from subroutine, it pulls the saved state back. After reset it fetches the start address and sets up the stack pointer and status. Instruction decoding and arithmetic happen elsewhere. The core presents its current status and program counter, and it takes `pc_out` and `status_out` when `done` pulses.

Memory is a single-port byte interface. Each busy cycle makes at most one access. `mem_rdata` must hold the addressed byte in the same cycle that `mem_re` is high. The stack pointer is kept inside the block and is visible on `sp_out`. `cost_out` gives the number of processor cycles that the finished operation accounts for.

The controller is one state machine. Its states are IDLE, RV_L, RV_H, PUSH_H, PUSH_L, PUSH_P, VEC_L, VEC_H, PULL_P, PULL_L, PULL_H and PAD.
- Reset places it in RV_L, then it goes RV_L to RV_H to PAD.
- From IDLE, an accepted NMI, IRQ or break goes to PUSH_H. It then runs PUSH_H to PUSH_L to PUSH_P to VEC_L to VEC_H to PAD.
- From IDLE, a return from interrupt goes to PULL_P. It then runs PULL_P to PULL_L to PULL_H to PAD.
- From IDLE, a return from subroutine goes to PULL_L. It then runs PULL_L to PULL_H to PAD.
- PAD repeats until the cycle budget of the operation is used up. It then returns to IDLE, and `done` is high in that final PAD cycle.

Top module: `irq_entry_seq`

## Requirements
- R1: A rising edge on `nmi_line` is latched as pending until it is serviced. When idle, a pending NMI is taken ahead of every other request, including an IRQ that arrives in the same cycle. NMI uses the vector at 0xFFFA (low byte) and 0xFFFB (high byte).
- R2: `irq_line` is level sensitive. It is taken only when status bit 2 (I) is 0. While I is 1 and no mask-clear is signalled, it causes no stack access and `busy` stays low.
- R3: Entry for a hardware interrupt writes, in order, PC[15:8], then PC[7:0], then the status with bit 4 (B) forced to 0. Each write goes to address 0x0100+SP, and SP then decreases by one, wrapping modulo 256.
- R4: Entry reads the vector low byte, then the high byte, and produces that word on `pc_out`. `status_out` is the entry status with bit 3 (D) cleared. IRQ also sets I. NMI leaves I unchanged. IRQ and break use the vector at 0xFFFE/0xFFFF.
- R5: A `go_brk` pulse pushes `pc_in`+1, high byte first, and then the status with B set to 1. It produces a status with B and I set and D cleared, and it loads the IRQ vector.
- R6: Interrupt entry and break each take 7 busy cycles. The two returns each take 6. The reset fetch takes 3. `done` is high only in the last busy cycle, and at that point `cost_out` equals the count.
- R7: Return from interrupt pulls the status, then PC low, then PC high. Each pull first adds one to SP and then reads 0x0100+SP. `status_out` is the pulled byte with bit 5 forced to 1.
- R8: Return from subroutine pulls PC low and then PC high. `pc_out` is that word plus one, and `status_out` passes `status_in` through.
- R9: When `mask_clr` is high in an idle cycle and `irq_line` is asserted, IRQ entry starts at once even if `status_in` still shows I=1. The pushed status has I and B cleared. `mask_clr` without an IRQ does nothing.
- R10: Reset sets SP to 0xFF and reads the vector at 0xFFFC/0xFFFD into `pc_out`. `status_out` becomes 0x22 (bit 1 Z and bit 5 set).
- R11: The stack pointer wraps inside page one in both directions. A pull from SP=0xFF reads 0x0100, and a push at SP=0x00 is followed by a push at 0x01FF.
- R12: Start pulses are sampled only in idle cycles. A start pulse that arrives while the block is busy is dropped. In an idle cycle, a hardware interrupt that is taken wins over a start pulse, and that pulse is dropped. An NMI edge seen while busy is serviced right after the current operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; starts the reset vector fetch |
| nmi_line | input | 1 | Non-maskable request, edge sensitive |
| irq_line | input | 1 | Maskable request, level sensitive |
| mask_clr | input | 1 | Pulse: the core has just cleared the I flag |
| go_brk | input | 1 | Pulse: start a software break |
| go_rti | input | 1 | Pulse: start a return from interrupt |
| go_rts | input | 1 | Pulse: start a return from subroutine |
| status_in | input | 8 | Current processor status |
| pc_in | input | 16 | Current program counter (return address to save) |
| mem_rdata | input | 8 | Read data, valid in the cycle mem_re is high |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | Last cycle of an operation; results valid |
| pc_out | output | 16 | New program counter |
| status_out | output | 8 | New processor status |
| sp_out | output | 8 | Stack pointer |
| cost_out | output | 4 | Cycle cost of the finished operation |

## Verification
The bench puts an NMI edge and an IRQ level in the same cycle. A wrong priority would push the IRQ frame first, or would lose the NMI. It drives pushes and pulls across the 0x00/0xFF boundary of the stack pointer. A pointer that does not wrap would leave page one or pull from 0x0200. It forces bit 5 through a return from interrupt and checks the B bit on both kinds of entry. A swapped B polarity, or a missing bit-5 force, shows up in the written stack byte or in `status_out`. It raises `mask_clr` while `status_in` still reads I=1 and fires start pulses while the block is busy or while an interrupt wins. A design without the immediate re-check would stay idle there, and one that does not drop the pulses would start an operation that was never accepted.

// File: rtl/isq_pkg.sv
package isq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RV_L,
        ST_RV_H,
        ST_PUSH_H,
        ST_PUSH_L,
        ST_PUSH_P,
        ST_VEC_L,
        ST_VEC_H,
        ST_PULL_P,
        ST_PULL_L,
        ST_PULL_H,
        ST_PAD
    } seq_state_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_NMI,
        EV_IRQ,
        EV_BRK,
        EV_RTI,
        EV_RTS
    } ev_kind_t;

    localparam int BIT_Z = 1;
    localparam int BIT_I = 2;
    localparam int BIT_D = 3;
    localparam int BIT_B = 4;
    localparam int BIT_R = 5;

    localparam logic [7:0] MSK_Z = 8'(1 << BIT_Z);
    localparam logic [7:0] MSK_I = 8'(1 << BIT_I);
    localparam logic [7:0] MSK_D = 8'(1 << BIT_D);
    localparam logic [7:0] MSK_B = 8'(1 << BIT_B);
    localparam logic [7:0] MSK_R = 8'(1 << BIT_R);

endpackage

// File: rtl/isq_nmi_latch.sv
module isq_nmi_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic take,
    output logic pend
);
    logic line_q;
    logic pend_q;
    logic rise;

    assign rise = line & ~line_q;
    assign pend = pend_q | rise;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            line_q <= line;
            pend_q <= pend & ~take;
        end
    end

    // R1: an edge that is not serviced stays pending
    a_r1_edge_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !take) |=> pend);

endmodule

// File: rtl/isq_arbiter.sv
module isq_arbiter
    import isq_pkg::*;
(
    input  logic     idle,
    input  logic     nmi_pend,
    input  logic     irq_line,
    input  logic     i_flag,
    input  logic     mask_clr,
    input  logic     go_brk,
    input  logic     go_rti,
    input  logic     go_rts,
    output ev_kind_t ev
);
    logic irq_ok;

    assign irq_ok = irq_line && (!i_flag || mask_clr);

    always_comb begin
        ev = EV_NONE;
        if (idle) begin
            if (nmi_pend)    ev = EV_NMI;
            else if (irq_ok) ev = EV_IRQ;
            else if (go_brk) ev = EV_BRK;
            else if (go_rti) ev = EV_RTI;
            else if (go_rts) ev = EV_RTS;
        end
    end

endmodule

// File: rtl/isq_stack.sv
module isq_stack #(
    parameter logic [7:0] PAGE    = 8'h01,
    parameter logic [7:0] SP_INIT = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push,
    input  logic        pull,
    output logic [7:0]  sp,
    output logic [15:0] push_addr,
    output logic [15:0] pull_addr
);
    logic [7:0] sp_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    sp_q <= SP_INIT;
        else if (push) sp_q <= sp_q - 8'd1;
        else if (pull) sp_q <= sp_q + 8'd1;
    end

    assign sp        = sp_q;
    assign push_addr = {PAGE, sp_q};
    assign pull_addr = {PAGE, sp_q + 8'd1};

    // R3: a push leaves SP one lower (modulo 256)
    a_r3_push_dec: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> sp == $past(sp) - 8'd1);
    // R7: a pull leaves SP one higher (modulo 256)
    a_r7_pull_inc: assert property (@(posedge clk) disable iff (!rst_n)
        pull |=> sp == $past(sp) + 8'd1);
    // R11: never both directions at once
    a_r11_one_dir: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pull));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import isq_pkg::*;
#(
    parameter logic [15:0] VEC_NMI    = 16'hFFFA,
    parameter logic [15:0] VEC_RST    = 16'hFFFC,
    parameter logic [15:0] VEC_IRQ    = 16'hFFFE,
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter int          COST_W     = 4,
    parameter int          COST_ENTRY = 7,
    parameter int          COST_RET   = 6,
    parameter int          COST_RST   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_line,
    input  logic              irq_line,
    input  logic              mask_clr,
    input  logic              go_brk,
    input  logic              go_rti,
    input  logic              go_rts,
    input  logic [7:0]        status_in,
    input  logic [15:0]       pc_in,
    input  logic [7:0]        mem_rdata,
    output logic [15:0]       mem_addr,
    output logic              mem_we,
    output logic              mem_re,
    output logic [7:0]        mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [15:0]       pc_out,
    output logic [7:0]        status_out,
    output logic [7:0]        sp_out,
    output logic [COST_W-1:0] cost_out
);
    localparam logic [COST_W-1:0] C_ENTRY = COST_W'(COST_ENTRY);
    localparam logic [COST_W-1:0] C_RET   = COST_W'(COST_RET);
    localparam logic [COST_W-1:0] C_RST   = COST_W'(COST_RST);
    localparam logic [7:0]        ST_BOOT = MSK_Z | MSK_R;

    seq_state_t state_q, state_d;
    ev_kind_t   ev, kind_q;
    logic       nmi_pend, take_nmi, start;
    logic       push, pull;
    logic [7:0] sp;
    logic [15:0] push_addr, pull_addr;

    logic [COST_W-1:0] rem_q, cost_q;
    logic [15:0] push_pc_q, pc_q, vec_q;
    logic [7:0]  push_st_q, st_q, lo_q;

    assign start    = (state_q == ST_IDLE) && (ev != EV_NONE);
    assign take_nmi = start && (ev == EV_NMI);

    isq_nmi_latch u_nmi (
        .clk  (clk),
        .rst_n(rst_n),
        .line (nmi_line),
        .take (take_nmi),
        .pend (nmi_pend)
    );

    isq_arbiter u_arb (
        .idle    (state_q == ST_IDLE),
        .nmi_pend(nmi_pend),
        .irq_line(irq_line),
        .i_flag  (status_in[BIT_I]),
        .mask_clr(mask_clr),
        .go_brk  (go_brk),
        .go_rti  (go_rti),
        .go_rts  (go_rts),
        .ev      (ev)
    );

    isq_stack #(.PAGE(STACK_PAGE), .SP_INIT(8'hFF)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pull     (pull),
        .sp       (sp),
        .push_addr(push_addr),
        .pull_addr(pull_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RV_L;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                unique case (ev)
                    EV_NMI, EV_IRQ, EV_BRK: state_d = ST_PUSH_H;
                    EV_RTI:                 state_d = ST_PULL_P;
                    EV_RTS:                 state_d = ST_PULL_L;
                    EV_NONE:                state_d = ST_IDLE;
                    default:                state_d = ST_IDLE;
                endcase
            end
            ST_RV_L:   state_d = ST_RV_H;
            ST_RV_H:   state_d = ST_PAD;
            ST_PUSH_H: state_d = ST_PUSH_L;
            ST_PUSH_L: state_d = ST_PUSH_P;
            ST_PUSH_P: state_d = ST_VEC_L;
            ST_VEC_L:  state_d = ST_VEC_H;
            ST_VEC_H:  state_d = ST_PAD;
            ST_PULL_P: state_d = ST_PULL_L;
            ST_PULL_L: state_d = ST_PULL_H;
            ST_PULL_H: state_d = ST_PAD;
            ST_PAD:    state_d = (rem_q == '0) ? ST_IDLE : ST_PAD;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_addr  = '0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        push      = 1'b0;
        pull      = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RV_L: begin mem_re = 1'b1; mem_addr = VEC_RST; end
            ST_RV_H: begin mem_re = 1'b1; mem_addr = VEC_RST + 16'd1; end
            ST_PUSH_H: begin
                mem_we = 1'b1; push = 1'b1; mem_addr = push_addr; mem_wdata = push_pc_q[15:8];
            end
            ST_PUSH_L: begin
                mem_we = 1'b1; push = 1'b1; mem_addr = push_addr; mem_wdata = push_pc_q[7:0];
            end
            ST_PUSH_P: begin
                mem_we = 1'b1; push = 1'b1; mem_addr = push_addr; mem_wdata = push_st_q;
            end
            ST_VEC_L: begin mem_re = 1'b1; mem_addr = vec_q; end
            ST_VEC_H: begin mem_re = 1'b1; mem_addr = vec_q + 16'd1; end
            ST_PULL_P, ST_PULL_L, ST_PULL_H: begin
                mem_re = 1'b1; pull = 1'b1; mem_addr = pull_addr;
            end
            ST_PAD: done = (rem_q == '0);
            default: ;
        endcase
    end

    // operation data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= C_RST - COST_W'(1);
            cost_q    <= C_RST;
            kind_q    <= EV_NONE;
            push_pc_q <= '0;
            push_st_q <= '0;
            vec_q     <= VEC_RST;
            pc_q      <= '0;
            st_q      <= ST_BOOT;
            lo_q      <= '0;
        end else begin
            if (start) begin
                kind_q    <= ev;
                push_pc_q <= pc_in;
                vec_q     <= VEC_IRQ;
                if (ev == EV_RTI || ev == EV_RTS) begin
                    rem_q  <= C_RET - COST_W'(1);
                    cost_q <= C_RET;
                end else begin
                    rem_q  <= C_ENTRY - COST_W'(1);
                    cost_q <= C_ENTRY;
                end
                unique case (ev)
                    EV_NMI: begin
                        push_st_q <= status_in & ~MSK_B;
                        st_q      <= status_in & ~MSK_D;
                        vec_q     <= VEC_NMI;
                    end
                    EV_IRQ: begin
                        push_st_q <= status_in & ~(MSK_B | MSK_I);
                        st_q      <= (status_in | MSK_I) & ~MSK_D;
                    end
                    EV_BRK: begin
                        push_pc_q <= pc_in + 16'd1;
                        push_st_q <= status_in | MSK_B;
                        st_q      <= (status_in | MSK_B | MSK_I) & ~MSK_D;
                    end
                    EV_RTS:  st_q <= status_in;
                    EV_RTI:  ;
                    EV_NONE: ;
                    default: ;
                endcase
            end else if (state_q != ST_IDLE && rem_q != '0) begin
                rem_q <= rem_q - COST_W'(1);
            end

            unique case (state_q)
                ST_RV_L, ST_VEC_L, ST_PULL_L: lo_q <= mem_rdata;
                ST_RV_H, ST_VEC_H:            pc_q <= {mem_rdata, lo_q};
                ST_PULL_H: pc_q <= {mem_rdata, lo_q} + ((kind_q == EV_RTS) ? 16'd1 : 16'd0);
                ST_PULL_P: st_q <= mem_rdata | MSK_R;
                default: ;
            endcase
        end
    end

    assign busy       = (state_q != ST_IDLE);
    assign pc_out     = pc_q;
    assign status_out = st_q;
    assign sp_out     = sp;
    assign cost_out   = cost_q;

    // checker support: busy cycles elapsed in the current operation
    logic [COST_W-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)                         run_cnt <= '0;
        else if (state_q == ST_IDLE || done) run_cnt <= '0;
        else                                 run_cnt <= run_cnt + COST_W'(1);
    end

    // R6: done lands in the cycle that matches the reported cost
    a_r6_cost_len: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_cnt + COST_W'(1)) == cost_out);
    // R1: an idle cycle with NMI pending starts the NMI frame
    a_r1_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && nmi_pend) |=> (state_q == ST_PUSH_H && kind_q == EV_NMI));
    // R2: a masked IRQ alone leaves the block idle
    a_r2_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && irq_line && status_in[BIT_I] && !mask_clr && !nmi_pend
         && !go_brk && !go_rti && !go_rts) |=> state_q == ST_IDLE);
    // R3: stack writes stay in page one
    a_r3_page_one: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_addr[15:8] == STACK_PAGE);
    // R12: one memory access per cycle
    a_r12_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        nmi_line = 1'b0, irq_line = 1'b0, mask_clr = 1'b0;
    logic        go_brk = 1'b0, go_rti = 1'b0, go_rts = 1'b0;
    logic [7:0]  status_in = 8'h00;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re, busy, done;
    logic [7:0]  mem_wdata, status_out, sp_out;
    logic [15:0] pc_out;
    logic [3:0]  cost_out;

    irq_entry_seq u_dut (
        .clk(clk), .rst_n(rst_n), .nmi_line(nmi_line), .irq_line(irq_line),
        .mask_clr(mask_clr), .go_brk(go_brk), .go_rti(go_rti), .go_rts(go_rts),
        .status_in(status_in), .pc_in(pc_in), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
        .busy(busy), .done(done), .pc_out(pc_out), .status_out(status_out),
        .sp_out(sp_out), .cost_out(cost_out)
    );

    // bench memory: stack page and vector words
    logic [7:0] stk [256];
    logic [7:0] vecmem [6];

    always_comb begin
        mem_rdata = 8'h00;
        if (mem_re) begin
            if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
            else if (int'(mem_addr) >= 'hFFFA) mem_rdata = vecmem[int'(mem_addr) - 'hFFFA];
        end
    end

    typedef struct {
        bit          we;
        bit          re;
        logic [15:0] addr;
        logic [7:0]  wd;
        bit          fin;
        logic [15:0] pc;
        logic [7:0]  st;
        logic [7:0]  sp;
        int          cost;
        string       req;
    } rec_t;

    rec_t q[$];
    int   nchk = 0, nerr = 0;
    bit   chk_en = 0, cur_idle = 0, finished = 0;
    string idle_req = "R12";

    logic [7:0] m_sp = 8'hFF;
    bit   m_pend = 0, m_prev = 0;

    function automatic logic [15:0] vec_word(int idx);
        return {vecmem[idx + 1], vecmem[idx]};
    endfunction

    function automatic void add(bit we, bit re, logic [15:0] a, logic [7:0] wd, string req);
        rec_t r;
        r.we = we; r.re = re; r.addr = a; r.wd = wd; r.fin = 0;
        r.pc = 0; r.st = 0; r.sp = 0; r.cost = 0; r.req = req;
        q.push_back(r);
    endfunction

    function automatic void add_fin(logic [15:0] pc, logic [7:0] st, logic [7:0] sp, int cost, string req);
        rec_t r;
        r.we = 0; r.re = 0; r.addr = 0; r.wd = 0; r.fin = 1;
        r.pc = pc; r.st = st; r.sp = sp; r.cost = cost; r.req = req;
        q.push_back(r);
    endfunction

    // kind: 1 NMI, 2 IRQ, 3 BRK
    function automatic void sched_entry(int kind, string req);
        logic [15:0] ps, pv;
        logic [7:0]  pst, nst, s;
        int vi;
        s  = m_sp;
        ps = (kind == 3) ? pc_in + 16'd1 : pc_in;
        if (kind == 3) begin
            pst = status_in | 8'h10;
            nst = (status_in | 8'h14) & 8'hF7;
        end else if (kind == 2) begin
            pst = status_in & 8'hEB;
            nst = (status_in | 8'h04) & 8'hF7;
        end else begin
            pst = status_in & 8'hEF;
            nst = status_in & 8'hF7;
        end
        vi = (kind == 1) ? 0 : 4;
        pv = vec_word(vi);
        add(1, 0, {8'h01, s},          ps[15:8], req);
        add(1, 0, {8'h01, s - 8'd1},   ps[7:0],  req);
        add(1, 0, {8'h01, s - 8'd2},   pst,      req);
        add(0, 1, 16'(16'hFFFA + vi),     0, req);
        add(0, 1, 16'(16'hFFFB + vi),     0, req);
        add(0, 0, 0, 0, req);
        add_fin(pv, nst, s - 8'd3, 7, req);
        m_sp = s - 8'd3;
    endfunction

    function automatic void sched_rti(string req);
        logic [7:0] s;
        s = m_sp;
        add(0, 1, {8'h01, s + 8'd1}, 0, req);
        add(0, 1, {8'h01, s + 8'd2}, 0, req);
        add(0, 1, {8'h01, s + 8'd3}, 0, req);
        add(0, 0, 0, 0, req); add(0, 0, 0, 0, req);
        add_fin({stk[s + 8'd3], stk[s + 8'd2]}, stk[s + 8'd1] | 8'h20, s + 8'd3, 6, req);
        m_sp = s + 8'd3;
    endfunction

    function automatic void sched_rts(string req);
        logic [7:0] s;
        s = m_sp;
        add(0, 1, {8'h01, s + 8'd1}, 0, req);
        add(0, 1, {8'h01, s + 8'd2}, 0, req);
        for (int i = 0; i < 3; i++) add(0, 0, 0, 0, req);
        add_fin({stk[s + 8'd2], stk[s + 8'd1]} + 16'd1, status_in, s + 8'd2, 6, req);
        m_sp = s + 8'd2;
    endfunction

    // predicts what the next clock edge starts
    task automatic model_eval();
        bit rise, pend;
        rise   = nmi_line && !m_prev;
        m_prev = nmi_line;
        pend   = m_pend || rise;
        if (cur_idle) begin
            if (pend) begin
                sched_entry(1, "R1");
                pend = 0;
            end else if (irq_line && (!status_in[2] || mask_clr)) sched_entry(2, mask_clr ? "R9" : "R4");
            else if (go_brk) sched_entry(3, "R5");
            else if (go_rti) sched_rti("R7");
            else if (go_rts) sched_rts("R8");
        end
        m_pend = pend;
    endtask

    task automatic check_cycle();
        rec_t r;
        if (q.size() == 0) begin
            cur_idle = 1;
            nchk++;
            if (busy !== 1'b0 || mem_we !== 1'b0 || mem_re !== 1'b0 || done !== 1'b0) begin
                nerr++;
                $display("FAIL %s: idle cycle got busy=%0b we=%0b re=%0b done=%0b, expected all 0",
                         idle_req, busy, mem_we, mem_re, done);
            end
        end else begin
            r = q.pop_front();
            cur_idle = 0;
            nchk++;
            if (busy !== 1'b1 || mem_we !== r.we || mem_re !== r.re || done !== r.fin ||
                ((r.we || r.re) && mem_addr !== r.addr) || (r.we && mem_wdata !== r.wd)) begin
                nerr++;
                $display("FAIL %s: busy=%0b we=%0b re=%0b addr=%h wd=%h done=%0b, expected busy=1 we=%0b re=%0b addr=%h wd=%h done=%0b",
                         r.req, busy, mem_we, mem_re, mem_addr, mem_wdata, done,
                         r.we, r.re, r.addr, r.wd, r.fin);
            end
            if (r.fin) begin
                nchk++;
                if (pc_out !== r.pc || status_out !== r.st || sp_out !== r.sp || int'(cost_out) != r.cost) begin
                    nerr++;
                    $display("FAIL %s/R6: pc=%h st=%h sp=%h cost=%0d, expected pc=%h st=%h sp=%h cost=%0d",
                             r.req, pc_out, status_out, sp_out, cost_out, r.pc, r.st, r.sp, r.cost);
                end
            end
        end
        if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] = mem_wdata;
    endtask

    task automatic clk_step();
        if (chk_en) model_eval();
        @(negedge clk);
        if (chk_en) check_cycle();
    endtask

    task automatic run_until_idle();
        for (int i = 0; i < 40; i++) begin
            clk_step();
            if (cur_idle) break;
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) stk[i] = 8'h00;
        vecmem[0] = 8'h10; vecmem[1] = 8'h9A;   // NMI  -> 0x9A10
        vecmem[2] = 8'h00; vecmem[3] = 8'hC0;   // reset-> 0xC000
        vecmem[4] = 8'hF0; vecmem[5] = 8'hE5;   // IRQ  -> 0xE5F0
        stk[0] = 8'h34; stk[1] = 8'h12;

        // R10: reset fetch
        for (int i = 0; i < 3; i++) clk_step();
        add(0, 1, 16'hFFFC, 0, "R10");
        add(0, 1, 16'hFFFD, 0, "R10");
        add_fin(16'hC000, 8'h22, 8'hFF, 3, "R10");
        chk_en = 1; cur_idle = 0;
        clk_step();
        rst_n = 1'b1;
        run_until_idle();

        // R8 / R11: return from subroutine pulling across the wrap
        status_in = 8'h20;
        go_rts = 1'b1; clk_step(); go_rts = 1'b0;
        run_until_idle();

        // R2: masked IRQ does nothing; R9: mask_clr without IRQ does nothing
        idle_req = "R2";
        status_in = 8'h24; irq_line = 1'b1;
        for (int i = 0; i < 4; i++) clk_step();
        irq_line = 1'b0; mask_clr = 1'b1; idle_req = "R9";
        clk_step(); mask_clr = 1'b0;
        clk_step();

        // R1 / R3 / R4 / R11: NMI and IRQ together, push wraps below 0x0100
        idle_req = "R1";
        status_in = 8'h30; pc_in = 16'h1234;
        nmi_line = 1'b1; irq_line = 1'b1;
        clk_step();
        run_until_idle();
        clk_step();                 // IRQ entry starts here
        irq_line = 1'b0; nmi_line = 1'b0;
        run_until_idle();

        // R5: software break
        status_in = 8'h01; pc_in = 16'h8000;
        go_brk = 1'b1; clk_step(); go_brk = 1'b0;
        run_until_idle();

        // R7: return from interrupt restores the break frame
        go_rti = 1'b1; clk_step(); go_rti = 1'b0;
        run_until_idle();

        // R9: mask clear with IRQ already asserted
        status_in = 8'h24; pc_in = 16'h4321; irq_line = 1'b1;
        clk_step();
        mask_clr = 1'b1; clk_step(); mask_clr = 1'b0; irq_line = 1'b0;
        run_until_idle();

        // R12: pulses while busy dropped, NMI edge while busy kept
        idle_req = "R12";
        status_in = 8'h00; pc_in = 16'h0777;
        go_rts = 1'b1; clk_step(); go_rts = 1'b0;
        go_brk = 1'b1; nmi_line = 1'b1; clk_step(); go_brk = 1'b0;
        clk_step(); nmi_line = 1'b0;
        run_until_idle();
        run_until_idle();

        // R12: interrupt beats a start pulse in the same cycle
        status_in = 8'h20; irq_line = 1'b1; go_rti = 1'b1;
        clk_step(); go_rti = 1'b0; irq_line = 1'b0;
        run_until_idle();
        for (int i = 0; i < 4; i++) clk_step();

        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

endmodule